// File: doc/BRIEF.md
# TLB Maintenance Instruction Access Gate

This block decides, in one combinational step, what happens when a 32-bit coprocessor system instruction that invalidates TLB entries by virtual address (for every address space, last level only, broadcast to the inner sharing domain) is issued. It first checks that the coprocessor encoding names this operation. It then checks that the 32-bit EL1 feature is present and that the current exception level is allowed to run it. Next it walks the hypervisor trap controls in a fixed priority. If nothing stops the instruction, it passes it on to the TLB block along with the regime and mode fields that block needs.

The result is a four-bit one-hot vector: undefined, trap to a 64-bit hypervisor, trap to a 32-bit hypervisor, or execute. Three extra outputs go with an execute result: the translation regime, whether the current virtual-machine identifier applies, and whether entries tagged with the fast-attribute (XS) marking are excluded. A trap result carries a trap code and a one-hot mark showing which control caused it. The block holds no state. There is no stream traffic at its edge, so every pin is a plain level.

Top module: `tlbi_gate`

## Requirements
- R1: The instruction is recognised only when cp_num=15, opc1=0, crn=8, crm=3 and opc2=7. Any other encoding raises no_match and drives result, trap_src, trap_code, regime_el3, id_valid and excl_attr to zero.
- R2: A recognised instruction gives result bit 0 (undefined) when has_el1_32 is 0, or when cur_el is 0.
- R3: At EL1, a trap path is active in one of two cases. The 64-bit path is active when el2_en=1, has_el2_64=1 and el2_aa32=0. The 32-bit path is active when el2_en=1, has_el2_32=1 and el2_aa32=1. On the active path the trap bits are tested in this order: group trap, then TLB trap, then broadcast TLB trap. The first bit that is set is reported in trap_src at bit 0, 1 or 2 respectively.
- R4: A trap on the 64-bit path gives result bit 1, and a trap on the 32-bit path gives result bit 2. Both set trap_code to 0x03. When there is no trap, trap_code is 0.
- R5: On the 32-bit path the broadcast trap is taken from h32b_bcast_trap (the second control register), not from h32_bcast_trap. The 64-bit path uses h64_bcast_trap.
- R6: At EL1 with no trap, the result is execute (bit 3) with regime_el3=0 and id_valid=1. excl_attr is 1 only when all of these hold: has_xs, has_el2_64, el2_aa32=0, has_ext_ctl, ext_ctl_en and ext_excl are all 1.
- R7: At EL2 the result is execute with regime_el3=0, id_valid=1 and excl_attr=0.
- R8: At EL3 the result is execute with regime_el3=1, id_valid=0 and excl_attr=0.
- R9: For a recognised encoding, result has exactly one bit set. regime_el3, id_valid and excl_attr are 0 unless the result is execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp_num | input | 4 | Coprocessor number |
| opc1 | input | 3 | First opcode field |
| crn | input | 4 | Primary register field |
| crm | input | 4 | Secondary register field |
| opc2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | EL2 is enabled in the current security state |
| el2_aa32 | input | 1 | EL2 runs in 32-bit state |
| has_el1_32 | input | 1 | 32-bit EL1 feature present |
| has_el2_64 | input | 1 | 64-bit EL2 feature present |
| has_el2_32 | input | 1 | 32-bit EL2 feature present |
| has_xs | input | 1 | Fast-attribute (XS) marking feature present |
| has_ext_ctl | input | 1 | Extended hypervisor control feature present |
| ext_ctl_en | input | 1 | Extended hypervisor control enabled |
| ext_excl | input | 1 | Extended control bit requesting XS exclusion |
| h64_grp_trap | input | 1 | 64-bit hypervisor: coprocessor group trap |
| h64_tlb_trap | input | 1 | 64-bit hypervisor: TLB maintenance trap |
| h64_bcast_trap | input | 1 | 64-bit hypervisor: broadcast TLB maintenance trap |
| h32_grp_trap | input | 1 | 32-bit hypervisor: coprocessor group trap |
| h32_tlb_trap | input | 1 | 32-bit hypervisor: TLB maintenance trap (first control register) |
| h32_bcast_trap | input | 1 | 32-bit hypervisor: broadcast trap copy in first control register (unused) |
| h32b_bcast_trap | input | 1 | 32-bit hypervisor: broadcast TLB trap (second control register) |
| no_match | output | 1 | Encoding is not this instruction |
| result | output | 4 | One-hot: 0 undefined, 1 trap64, 2 trap32, 3 execute |
| trap_src | output | 3 | One-hot winning trap control: 0 group, 1 TLB, 2 broadcast |
| trap_code | output | 6 | 0x03 on a trap, else 0 |
| regime_el3 | output | 1 | Execute targets the EL3 regime (0 means EL1&0) |
| id_valid | output | 1 | Execute uses the current virtual-machine identifier |
| excl_attr | output | 1 | Execute excludes XS-marked entries |

## Verification
The block has no state, so any fault shows on the ports in the same evaluation as the input change that exposes it. Each input vector is therefore a complete test. A wrong priority order shows up as the wrong trap_src bit whenever two or more trap bits are set together. Reading the wrong register for a trap bit, or picking the wrong path, shows up as a trap where execute was expected, or a trap reported on the other path. A fault in the exclusion condition shows up as excl_attr disagreeing with the six-way AND on some EL1 vector.

// File: rtl/tlbi_gate_pkg.sv
package tlbi_gate_pkg;
  localparam int RES_W     = 4;
  localparam int RES_UNDEF = 0;
  localparam int RES_T64   = 1;
  localparam int RES_T32   = 2;
  localparam int RES_EXEC  = 3;

  localparam int SRC_W     = 3;
  localparam int N_PATHS   = 2;
  localparam int PATH_64   = 0;
  localparam int PATH_32   = 1;

  typedef struct packed {
    logic grp;
    logic tlb;
    logic bcast;
  } trap_bits_t;
endpackage

// File: rtl/tlbi_enc_match.sv
module tlbi_enc_match #(
  parameter int CP_W   = 4,
  parameter int OP1_W  = 3,
  parameter int CR_W   = 4,
  parameter int OP2_W  = 3,
  parameter logic [CP_W-1:0]  CP_VAL  = 4'd15,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'd0,
  parameter logic [CR_W-1:0]  CRN_VAL = 4'd8,
  parameter logic [CR_W-1:0]  CRM_VAL = 4'd3,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'd7
) (
  input  logic [CP_W-1:0]  cp_num,
  input  logic [OP1_W-1:0] opc1,
  input  logic [CR_W-1:0]  crn,
  input  logic [CR_W-1:0]  crm,
  input  logic [OP2_W-1:0] opc2,
  output logic             hit
);
  localparam int N_FIELDS = 5;
  logic [N_FIELDS-1:0] field_ok;

  always_comb begin
    field_ok[0] = (cp_num == CP_VAL);
    field_ok[1] = (opc1 == OP1_VAL);
    field_ok[2] = (crn == CRN_VAL);
    field_ok[3] = (crm == CRM_VAL);
    field_ok[4] = (opc2 == OP2_VAL);
    hit = &field_ok;
  end
endmodule

// File: rtl/tlbi_trap_chain.sv
module tlbi_trap_chain
  import tlbi_gate_pkg::*;
(
  input  logic        path_active,
  input  trap_bits_t  ctl,
  output logic        trap,
  output logic [SRC_W-1:0] src
);
  always_comb begin
    src = '0;
    if (path_active) begin
      if (ctl.grp)        src[0] = 1'b1;
      else if (ctl.tlb)   src[1] = 1'b1;
      else if (ctl.bcast) src[2] = 1'b1;
    end
    trap = |src;
  end

  always_comb begin
    // R3
    trap_src_onehot_chk: assert ($onehot0(src));
  end
endmodule

// File: rtl/tlbi_exec_sel.sv
module tlbi_exec_sel (
  input  logic [1:0] cur_el,
  input  logic       excl_ok,
  output logic       regime_el3,
  output logic       id_valid,
  output logic       excl_attr
);
  always_comb begin
    regime_el3 = 1'b0;
    id_valid   = 1'b0;
    excl_attr  = 1'b0;
    unique case (cur_el)
      2'd1: begin
        id_valid  = 1'b1;
        excl_attr = excl_ok;
      end
      2'd2: id_valid = 1'b1;
      2'd3: regime_el3 = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tlbi_gate.sv
module tlbi_gate
  import tlbi_gate_pkg::*;
#(
  parameter int TC_W = 6,
  parameter logic [TC_W-1:0] TRAP_CODE_VAL = 6'h03
) (
  input  logic [3:0] cp_num,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  input  logic [1:0] cur_el,
  input  logic       el2_en,
  input  logic       el2_aa32,
  input  logic       has_el1_32,
  input  logic       has_el2_64,
  input  logic       has_el2_32,
  input  logic       has_xs,
  input  logic       has_ext_ctl,
  input  logic       ext_ctl_en,
  input  logic       ext_excl,
  input  logic       h64_grp_trap,
  input  logic       h64_tlb_trap,
  input  logic       h64_bcast_trap,
  input  logic       h32_grp_trap,
  input  logic       h32_tlb_trap,
  input  logic       h32_bcast_trap,
  input  logic       h32b_bcast_trap,
  output logic       no_match,
  output logic [RES_W-1:0] result,
  output logic [SRC_W-1:0] trap_src,
  output logic [TC_W-1:0]  trap_code,
  output logic       regime_el3,
  output logic       id_valid,
  output logic       excl_attr
);
  logic enc_hit;
  logic is_undef;
  logic at_el1;
  logic [N_PATHS-1:0] path_on;
  trap_bits_t         path_ctl [N_PATHS];
  logic [N_PATHS-1:0] path_trap;
  logic [SRC_W-1:0]   path_src [N_PATHS];
  logic excl_ok;
  logic x_regime, x_id, x_excl;
  logic h32_bcast_unused;

  // The first 32-bit control register's broadcast copy has no effect.
  assign h32_bcast_unused = h32_bcast_trap;

  tlbi_enc_match u_match (
    .cp_num (cp_num),
    .opc1   (opc1),
    .crn    (crn),
    .crm    (crm),
    .opc2   (opc2),
    .hit    (enc_hit)
  );

  always_comb begin
    is_undef = !has_el1_32 || (cur_el == 2'd0);
    at_el1   = (cur_el == 2'd1);
    path_on[PATH_64] = at_el1 && el2_en && has_el2_64 && !el2_aa32;
    path_on[PATH_32] = at_el1 && el2_en && has_el2_32 && el2_aa32;
    path_ctl[PATH_64] = '{grp: h64_grp_trap, tlb: h64_tlb_trap, bcast: h64_bcast_trap};
    path_ctl[PATH_32] = '{grp: h32_grp_trap, tlb: h32_tlb_trap, bcast: h32b_bcast_trap};
    excl_ok = has_xs && has_el2_64 && !el2_aa32 && has_ext_ctl && ext_ctl_en && ext_excl;
  end

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    tlbi_trap_chain u_chain (
      .path_active (path_on[p]),
      .ctl         (path_ctl[p]),
      .trap        (path_trap[p]),
      .src         (path_src[p])
    );
  end

  tlbi_exec_sel u_exec (
    .cur_el     (cur_el),
    .excl_ok    (excl_ok),
    .regime_el3 (x_regime),
    .id_valid   (x_id),
    .excl_attr  (x_excl)
  );

  always_comb begin
    no_match   = !enc_hit;
    result     = '0;
    trap_src   = '0;
    trap_code  = '0;
    regime_el3 = 1'b0;
    id_valid   = 1'b0;
    excl_attr  = 1'b0;
    if (enc_hit) begin
      if (is_undef) begin
        result[RES_UNDEF] = 1'b1;
      end else if (path_trap[PATH_64]) begin
        result[RES_T64] = 1'b1;
        trap_src  = path_src[PATH_64];
        trap_code = TRAP_CODE_VAL;
      end else if (path_trap[PATH_32]) begin
        result[RES_T32] = 1'b1;
        trap_src  = path_src[PATH_32];
        trap_code = TRAP_CODE_VAL;
      end else begin
        result[RES_EXEC] = 1'b1;
        regime_el3 = x_regime;
        id_valid   = x_id;
        excl_attr  = x_excl;
      end
    end
  end

  always_comb begin
    // R1
    nomatch_quiet_chk: assert (!no_match || (result == '0 && trap_code == '0 && !excl_attr));
    // R9
    result_onehot_chk: assert (no_match || $countones(result) == 1);
    // R4
    trap_code_chk: assert ((trap_code != '0) == (result[RES_T64] || result[RES_T32]));
    // R3
    src_with_trap_chk: assert ((trap_src != '0) == (trap_code != '0));
    // R6
    excl_el1_only_chk: assert (!excl_attr || (result[RES_EXEC] && cur_el == 2'd1));
    // R8
    el3_no_id_chk: assert (!regime_el3 || !id_valid);
  end
endmodule

// File: tb/tlbi_gate_tb.sv
module tlbi_gate_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [3:0] cp_num, crn, crm;
  logic [2:0] opc1, opc2;
  logic [1:0] cur_el;
  logic el2_en, el2_aa32, has_el1_32, has_el2_64, has_el2_32, has_xs;
  logic has_ext_ctl, ext_ctl_en, ext_excl;
  logic h64_grp_trap, h64_tlb_trap, h64_bcast_trap;
  logic h32_grp_trap, h32_tlb_trap, h32_bcast_trap, h32b_bcast_trap;
  logic no_match, regime_el3, id_valid, excl_attr;
  logic [3:0] result;
  logic [2:0] trap_src;
  logic [5:0] trap_code;

  tlbi_gate u_dut (
    .cp_num(cp_num), .opc1(opc1), .crn(crn), .crm(crm), .opc2(opc2),
    .cur_el(cur_el), .el2_en(el2_en), .el2_aa32(el2_aa32),
    .has_el1_32(has_el1_32), .has_el2_64(has_el2_64), .has_el2_32(has_el2_32),
    .has_xs(has_xs), .has_ext_ctl(has_ext_ctl), .ext_ctl_en(ext_ctl_en),
    .ext_excl(ext_excl), .h64_grp_trap(h64_grp_trap), .h64_tlb_trap(h64_tlb_trap),
    .h64_bcast_trap(h64_bcast_trap), .h32_grp_trap(h32_grp_trap),
    .h32_tlb_trap(h32_tlb_trap), .h32_bcast_trap(h32_bcast_trap),
    .h32b_bcast_trap(h32b_bcast_trap), .no_match(no_match), .result(result),
    .trap_src(trap_src), .trap_code(trap_code), .regime_el3(regime_el3),
    .id_valid(id_valid), .excl_attr(excl_attr)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic set_enc(input logic [3:0] c, input logic [2:0] o1,
                         input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2);
    cp_num = c; opc1 = o1; crn = n; crm = m; opc2 = o2;
  endtask

  task automatic apply_ctx(input logic [16:0] v);
    cur_el          = v[1:0];
    el2_en          = v[2];
    el2_aa32        = v[3];
    has_el1_32      = v[4];
    has_el2_64      = v[5];
    has_el2_32      = v[6];
    has_xs          = v[7];
    has_ext_ctl     = v[8];
    ext_ctl_en      = v[9];
    ext_excl        = v[10];
    h64_grp_trap    = v[11];
    h64_tlb_trap    = v[12];
    h64_bcast_trap  = v[13];
    h32_grp_trap    = v[14];
    h32_tlb_trap    = v[15];
    h32b_bcast_trap = v[16];
  endtask

  // Model built from the requirement text.
  task automatic check_ctx();
    int e_res, e_src, e_code, e_reg, e_id, e_ex;
    bit p64, p32;
    e_src = 0; e_code = 0; e_reg = 0; e_id = 0; e_ex = 0;
    p64 = (cur_el == 1) && el2_en && has_el2_64 && !el2_aa32;
    p32 = (cur_el == 1) && el2_en && has_el2_32 && el2_aa32;
    if (!has_el1_32 || cur_el == 0) e_res = 1;
    else if (p64 && (h64_grp_trap || h64_tlb_trap || h64_bcast_trap)) begin
      e_res = 2; e_code = 3;
      e_src = h64_grp_trap ? 1 : (h64_tlb_trap ? 2 : 4);
    end else if (p32 && (h32_grp_trap || h32_tlb_trap || h32b_bcast_trap)) begin
      e_res = 4; e_code = 3;
      e_src = h32_grp_trap ? 1 : (h32_tlb_trap ? 2 : 4);
    end else begin
      e_res = 8;
      if (cur_el == 3) e_reg = 1; else e_id = 1;
      if (cur_el == 1)
        e_ex = int'(has_xs && has_el2_64 && !el2_aa32 && has_ext_ctl && ext_ctl_en && ext_excl);
    end
    if (e_res == 1)      chk("R2", "result", result, e_res);
    else if (e_res == 8) chk("R9", "result", result, e_res);
    else                 chk("R4", "result", result, e_res);
    chk("R3", "trap_src", trap_src, e_src);
    chk("R4", "trap_code", trap_code, e_code);
    if (cur_el == 3)      chk("R8", "regime/id/excl", {regime_el3, id_valid, excl_attr}, {e_reg[0], e_id[0], e_ex[0]});
    else if (cur_el == 2) chk("R7", "regime/id/excl", {regime_el3, id_valid, excl_attr}, {e_reg[0], e_id[0], e_ex[0]});
    else                  chk("R6", "regime/id/excl", {regime_el3, id_valid, excl_attr}, {e_reg[0], e_id[0], e_ex[0]});
    chk("R1", "no_match", no_match, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    h32_bcast_trap = 1'b0;
    set_enc(4'd15, 3'd0, 4'd8, 4'd3, 3'd7);
    apply_ctx('0);
    #5;
    // Quiet starting state: EL0 is undefined (R2)
    chk("R2", "initial result", result, 1);
    chk("R1", "initial no_match", no_match, 0);

    // Full sweep of the context space for a matching encoding
    for (int v = 0; v < (1 << 17); v++) begin
      apply_ctx(v[16:0]);
      h32_bcast_trap = v[0] ^ v[5];
      #1;
      check_ctx();
    end

    // R5: 32-bit path, only the first-register broadcast copy set -> execute
    apply_ctx('0);
    cur_el = 2'd1; has_el1_32 = 1; el2_en = 1; el2_aa32 = 1; has_el2_32 = 1;
    h32_bcast_trap = 1; #1;
    chk("R5", "first-reg bcast ignored", result, 8);
    h32_bcast_trap = 0; h32b_bcast_trap = 1; #1;
    chk("R5", "second-reg bcast traps", result, 4);
    chk("R5", "second-reg bcast src", trap_src, 4);
    h32b_bcast_trap = 0; h64_bcast_trap = 1; #1;
    chk("R5", "64-bit bcast unused on 32 path", result, 8);

    // R1: single-field deviations from the recognised encoding
    apply_ctx('0);
    cur_el = 2'd3; has_el1_32 = 1;
    for (int k = 0; k < 16; k++) begin
      for (int f = 0; f < 5; f++) begin
        bit hit;
        set_enc(4'd15, 3'd0, 4'd8, 4'd3, 3'd7);
        case (f)
          0: begin cp_num = k[3:0]; hit = (k == 15); end
          1: begin opc1 = k[2:0]; hit = (k[2:0] == 0); end
          2: begin crn = k[3:0]; hit = (k == 8); end
          3: begin crm = k[3:0]; hit = (k == 3); end
          default: begin opc2 = k[2:0]; hit = (k[2:0] == 7); end
        endcase
        #1;
        chk("R1", "no_match", no_match, int'(!hit));
        chk("R1", "result", result, hit ? 8 : 0);
        chk("R1", "fields", {trap_src, trap_code, regime_el3, id_valid, excl_attr},
            hit ? 12'b000_000000_100 : 12'd0);
      end
    end

    // R1: mismatch while a trap would otherwise fire
    set_enc(4'd14, 3'd0, 4'd8, 4'd3, 3'd7);
    apply_ctx('0);
    cur_el = 2'd1; has_el1_32 = 1; el2_en = 1; has_el2_64 = 1; h64_grp_trap = 1;
    #1;
    chk("R1", "trap suppressed", {result, trap_src, trap_code}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule